// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus that owns a single 8-bit setting. Both bus lines come in as plain samples in the system clock domain. Each line passes through a two-flop synchronizer and a digital deglitch filter whose length is a parameter. The controller then works from the filtered levels. It finds START and STOP conditions and compares the first seven bits after a START against a fixed device address. On a match it pulls the data line low for the acknowledge slot. It then either accepts bytes into the register (write) or shifts the register out most significant bit first (read).

Downstream logic sees the register value at all times. It is also given a one-cycle update pulse when a STOP closes a transaction that wrote at least one byte. This lets it act on a new setting once per transaction instead of once per byte. The whole interface is gated by a mode input. While that input is low, the block ignores the bus and never pulls the data line. The data line output is open-drain in form: a single pull-enable, where 1 means "pull low" and 0 means "release".

Top module: `twc_cfg_slave`

## Requirements
- R1: Reset (synchronous, active high) clears the register to 0x00, releases the data line, holds the update pulse low, and returns the controller to idle.
- R2: A level change on either bus line that lasts fewer than FILT_LEN system clocks is discarded. It causes no START, no STOP and no extra bit.
- R3: After a START, the first 8 bits are the address (7 bits, MSB first) followed by a direction bit (0 = write, 1 = read). The block pulls the data line low in the ninth slot only when the address equals DEV_ADDR (default 7'b1100111). On any other address it stays released, including for all later bytes, until the next START.
- R4: In a write, every following byte is acknowledged with a low ninth slot and loaded into the register. With several bytes before STOP, the last one remains.
- R5: In a read, the block drives the register MSB first. It releases the line in the ninth slot so the master can answer. While the master answers low, the same value is sent again.
- R6: When the master answers high (not acknowledged) after a read byte, the block keeps the data line released until the next STOP or START.
- R7: `cfg_update` is high for exactly one cycle after a STOP, and only if at least one data byte was written since the previous STOP (a repeated START does not clear this). Otherwise it stays low.
- R8: While `mode_en` is low, the data line is never pulled, the register keeps its value and no update pulse is produced.
- R9: The pull-enable only asserts while the filtered clock line is low, so the block never creates a START or STOP of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Interface enable; low makes the block ignore the bus |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line (wired-AND level of the bus) |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_q | output | 8 | Current register value |
| cfg_update | output | 1 | One-cycle pulse after a STOP that ended a write |

## Verification
The bench builds the block with FILT_LEN = 3 and the default address. This keeps each bus phase at ten system clocks, so every bit slot fits comfortably after the synchronizer and filter delay. It also brings many whole transactions into the cycle budget. Values that step across the full byte range are written and read back. All seven single-bit neighbours of the device address are tried. Two-cycle spikes are injected on the clock line during a low phase and on the data line during a high phase, where an accepted spike would add a bit or fake a START.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } twc_state_e;
endpackage

// File: rtl/twc_deglitch.sv
module twc_deglitch #(
  parameter int LEN = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CW = (LEN > 1) ? $clog2(LEN + 1) : 1;

  logic [1:0]    sync_q;
  logic          s_lvl;
  logic [CW-1:0] cnt;

  assign s_lvl = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= 2'b11;
      clean_out <= 1'b1;
      cnt       <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_in};
      if (s_lvl != clean_out) begin
        if (cnt == CW'(LEN - 1)) begin
          clean_out <= s_lvl;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  generate
    if (LEN > 1) begin : g_chk
      // R2
      spike_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && clean_out != $past(clean_out))
          |-> ($past(s_lvl) == clean_out && $past(s_lvl, 2) == clean_out));
    end
  endgenerate
endmodule

// File: rtl/twc_bus_events.sv
module twc_bus_events #(
  parameter int FILT_LEN = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_f,
  output logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] raw_v, filt_v;
  logic       scl_p, sda_p;

  assign raw_v = {scl_raw, sda_raw};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_line
      twc_deglitch #(.LEN(FILT_LEN)) u_flt (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (raw_v[i]),
        .clean_out(filt_v[i])
      );
    end
  endgenerate

  assign scl_f = filt_v[1];
  assign sda_f = filt_v[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/twc_ctrl.sv
module twc_ctrl
  import twc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1100111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] cfg_q,
  output logic              cfg_update
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  twc_state_e        state;
  logic [BYTE_W-1:0] sh;
  logic [BCW-1:0]    bit_cnt;
  logic              rw, phase, wrote;

  always_ff @(posedge clk) begin
    cfg_update <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      sh       <= '0;
      bit_cnt  <= '0;
      rw       <= 1'b0;
      phase    <= 1'b0;
      wrote    <= 1'b0;
      sda_pull <= 1'b0;
      cfg_q    <= '0;
    end else if (!mode_en) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      wrote    <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_ev) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      sda_pull   <= 1'b0;
      cfg_update <= wrote;
      wrote      <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      phase    <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (scl_rise) begin
          sh      <= {sh[BYTE_W-2:0], sda_f};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            if (sh[ADDR_W-1:0] == DEV_ADDR) begin
              state <= ST_AACK;
              rw    <= sda_f;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK, ST_WACK: if (scl_fall) begin
          if (!phase) begin
            sda_pull <= 1'b1;
            phase    <= 1'b1;
          end else begin
            phase   <= 1'b0;
            bit_cnt <= '0;
            if (state == ST_AACK && rw) begin
              state    <= ST_RDATA;
              sh       <= cfg_q;
              sda_pull <= ~cfg_q[BYTE_W-1];
            end else begin
              state    <= ST_WDATA;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_WDATA: if (scl_rise) begin
          sh      <= {sh[BYTE_W-2:0], sda_f};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            cfg_q <= {sh[BYTE_W-2:0], sda_f};
            wrote <= 1'b1;
            state <= ST_WACK;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) phase <= 1'b1;
          end else if (scl_fall) begin
            if (phase) begin
              phase    <= 1'b0;
              sda_pull <= 1'b0;
              state    <= ST_RACK;
            end else begin
              sh       <= {sh[BYTE_W-2:0], 1'b0};
              sda_pull <= ~sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (!sda_f) phase <= 1'b1;
            else        state <= ST_SKIP;
          end else if (scl_fall && phase) begin
            phase    <= 1'b0;
            bit_cnt  <= '0;
            state    <= ST_RDATA;
            sh       <= cfg_q;
            sda_pull <= ~cfg_q[BYTE_W-1];
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_en) |-> (!sda_pull && !cfg_update));
  // R9
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_f);
  // R7
  update_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_update |=> !cfg_update);
  // R4
  cfg_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg_q != $past(cfg_q))
      |-> ($past(state) == ST_WDATA && $past(scl_rise)));
  // R6
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_pull);
endmodule

// File: rtl/twc_cfg_slave.sv
module twc_cfg_slave #(
  parameter int          FILT_LEN = 13,
  parameter logic [6:0]  DEV_ADDR = 7'b1100111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_en,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [7:0] cfg_q,
  output logic       cfg_update
);
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

  twc_bus_events #(.FILT_LEN(FILT_LEN)) u_ev (
    .clk     (clk),
    .rst     (rst),
    .scl_raw (scl_in),
    .sda_raw (sda_in),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  twc_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_en   (mode_en),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_pull  (sda_pull),
    .cfg_q     (cfg_q),
    .cfg_update(cfg_update)
  );

  // R7
  upd_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_update |-> $past(stop_ev));
endmodule

// File: tb/twc_cfg_slave_bench.sv
module twc_cfg_slave_bench;
  localparam int H = 10;
  localparam logic [6:0] ADDR = 7'b1100111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, cfg_update;
  logic [7:0] cfg_q;
  logic sda_bus;
  logic glitch_scl = 1'b0, glitch_sda = 1'b0;
  int checks = 0, errors = 0, upd_cnt = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  twc_cfg_slave #(.FILT_LEN(3), .DEV_ADDR(ADDR)) u_twc_cfg_slave (
    .clk(clk), .rst(rst), .mode_en(mode_en), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .cfg_q(cfg_q), .cfg_update(cfg_update)
  );

  always @(posedge clk) if (cfg_update) upd_cnt <= upd_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    if (glitch_scl) begin scl_m = 1'b1; hold(2); scl_m = 1'b0; end
    sda_m = b; hold(H);
    scl_m = 1'b1; hold(H / 2);
    if (glitch_sda && b) begin sda_m = 1'b0; hold(2); sda_m = 1'b1; end
    hold(H / 2);
    r = sda_bus; hold(H);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic do_start;
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(2 * H);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(v[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); v[i] = r; end
    bit_io(!give_ack, r);
  endtask

  initial begin
    bit a0, a1, a2;
    logic [7:0] rv, rv2;
    logic r;
    int u0;
    hold(5); rst = 1'b0; hold(2);
    // R1 reset state
    chk(cfg_q == 8'h00, "R1", cfg_q, 0);
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);
    chk(cfg_update == 1'b0, "R1", cfg_update, 0);

    // R3 R4 R5 R7: sweep across the byte range
    for (int v = 1; v < 256; v += 11) begin
      u0 = upd_cnt;
      do_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'(v), a1); do_stop;
      chk(a0, "R3", a0, 1);
      chk(a1, "R4", a1, 1);
      chk(cfg_q == 8'(v), "R4", cfg_q, v);
      chk(upd_cnt - u0 == 1, "R7", upd_cnt - u0, 1);
      do_start; send_byte({ADDR, 1'b1}, a0); recv_byte(1'b0, rv); do_stop;
      chk(rv == 8'(v), "R5", rv, v);
    end

    // R4 R7: three bytes in one write, last wins, one pulse
    u0 = upd_cnt;
    do_start; send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h11, a1); send_byte(8'h22, a2); send_byte(8'hC3, a0); do_stop;
    chk(a1 && a2 && a0, "R4", a1 + a2 + a0, 3);
    chk(cfg_q == 8'hC3, "R4", cfg_q, 195);
    chk(upd_cnt - u0 == 1, "R7", upd_cnt - u0, 1);

    // R5 R6: continuous read, then master NACK
    u0 = upd_cnt;
    do_start; send_byte({ADDR, 1'b1}, a0);
    recv_byte(1'b1, rv); recv_byte(1'b1, rv2);
    chk(rv == 8'hC3 && rv2 == 8'hC3, "R5", rv2, 195);
    recv_byte(1'b0, rv);
    chk(rv == 8'hC3, "R5", rv, 195);
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); chk(r == 1'b1, "R6", r, 1); end
    do_stop;
    chk(upd_cnt == u0, "R7", upd_cnt - u0, 0);

    // R3: every single-bit neighbour of the address is refused
    for (int k = 0; k < 7; k++) begin
      u0 = upd_cnt;
      do_start; send_byte({ADDR ^ 7'(1 << k), 1'b0}, a0); send_byte(8'h5A, a1); do_stop;
      chk(!a0 && !a1, "R3", a0 + a1, 0);
      chk(cfg_q == 8'hC3 && upd_cnt == u0, "R3", cfg_q, 195);
    end

    // R7: address-only write gives no pulse
    u0 = upd_cnt;
    do_start; send_byte({ADDR, 1'b0}, a0); do_stop;
    chk(a0 && upd_cnt == u0, "R7", upd_cnt - u0, 0);

    // R7: write, repeated START, read, STOP -> one pulse
    u0 = upd_cnt;
    do_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'h3C, a1);
    do_start; send_byte({ADDR, 1'b1}, a2); recv_byte(1'b0, rv); do_stop;
    chk(rv == 8'h3C && a2, "R5", rv, 60);
    chk(upd_cnt - u0 == 1, "R7", upd_cnt - u0, 1);

    // R8: mode low ignores a matching write
    mode_en = 1'b0; u0 = upd_cnt;
    do_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'hA5, a1); do_stop;
    chk(!a0 && !a1, "R8", a0 + a1, 0);
    chk(cfg_q == 8'h3C && upd_cnt == u0, "R8", cfg_q, 60);
    mode_en = 1'b1; hold(4);

    // R2: short spikes on SCL (low phase) and SDA (high phase)
    glitch_scl = 1'b1; glitch_sda = 1'b1;
    do_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'hB7, a1); do_stop;
    glitch_scl = 1'b0; glitch_sda = 1'b0;
    chk(a0 && a1, "R2", a0 + a1, 2);
    chk(cfg_q == 8'hB7, "R2", cfg_q, 183);

    // R1: reset after a write
    @(negedge clk); rst = 1'b1; hold(3); rst = 1'b0; hold(2);
    chk(cfg_q == 8'h00 && sda_pull == 1'b0, "R1", cfg_q, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule